// File: doc/BRIEF.md
# Decoded Micro-op Cache with Front-End Gating

This block sits beside the instruction decoder and keeps groups of micro-ops that were decoded earlier, keyed by the fetch address. Each fetch address is looked up in the cache before any decode work starts. On a hit, the stored group is streamed downstream and the fetch and decode stages are switched off. On a miss, a request goes to the decoder. The decoder's reply is streamed out and also written into the cache. Every reply is written; there is no admission filter.

A small loop detector watches the stream for fetch groups that end in a taken backward branch. When the same target comes back for enough consecutive iterations and the body fits its buffer, the block enters loop mode. In loop mode it replays the captured body from its own storage, with fetch, decode and branch prediction all switched off. A mispredict from the back end ends loop mode.

Top module: `uop_cache_fe`

## Requirements
- R1: The cache is direct mapped. The line index is the low log2(LINES) bits of the fetch address and the tag is the remaining bits. Two addresses with the same index and different tags evict each other.
- R2: Every decoder reply is written into the line for its address. A later fetch of that address hits, as long as no eviction or flush happened in between.
- R3: The lookup happens when the fetch is accepted. A hit raises no decoder request. A miss raises exactly one request, carrying the fetch address, and holds it until the reply arrives. A fetch is accepted only while no group is being served.
- R4: On a hit, the stored micro-ops are streamed in order starting the cycle after acceptance. From that cycle fetch_en_o and decode_en_o are low and bpred_en_o is high.
- R5: On a miss, fetch_en_o and decode_en_o are high from the cycle after acceptance. The decoder's micro-ops are streamed in order, lowest slot (bits [UOP_W-1:0]) first, and the number of micro-ops equals the reply count.
- R6: While uop_valid_o is high and uop_ready_i is low, the same micro-op stays on uop_o in the next cycle. The only exception is a mispredict ending loop mode.
- R7: When a group flagged as ending in a backward branch finishes streaming, and this is the 3rd consecutive such group with the same target, and the body captured since the previous one is 1 to 28 micro-ops, loop mode starts. In loop mode fetch_ready_o and all three enables are low, and the body is replayed cyclically from its first micro-op.
- R8: If the body between two backward branches exceeds 28 micro-ops, the iteration count restarts. Loop mode is never entered for that body.
- R9: A mispredict in loop mode ends it. The next cycle has fetch_ready_o, fetch_en_o, decode_en_o and bpred_en_o high. A mispredict outside loop mode restarts the iteration count.
- R10: A flush pulse clears every valid bit in one cycle, so every following lookup misses until lines are refilled.
- R11: After reset, fetch_ready_o and all enables are high, and uop_valid_o and dec_req_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| fetch_valid_i | input | 1 | Fetch address presented |
| fetch_ready_o | output | 1 | Block can accept a fetch |
| fetch_addr_i | input | ADDR_W | Fetch group address |
| fetch_bwd_i | input | 1 | Group ends in a taken backward branch |
| fetch_tgt_i | input | ADDR_W | Target of that backward branch |
| dec_req_valid_o | output | 1 | Decode request, held until reply |
| dec_req_addr_o | output | ADDR_W | Address to decode |
| dec_rsp_valid_i | input | 1 | Decoder reply valid (one cycle) |
| dec_rsp_cnt_i | input | CNT_W | Number of micro-ops in reply |
| dec_rsp_uops_i | input | MAX_UOPS*UOP_W | Packed micro-ops, slot 0 in low bits |
| uop_valid_o | output | 1 | Micro-op available |
| uop_ready_i | input | 1 | Consumer accepts micro-op |
| uop_o | output | UOP_W | Micro-op |
| mispredict_i | input | 1 | Back-end branch mispredict |
| fetch_en_o | output | 1 | Fetch stage enable |
| decode_en_o | output | 1 | Decode stage enable |
| bpred_en_o | output | 1 | Branch predictor enable |

## Verification
The assertions check on every cycle that a stalled micro-op holds still, and that the fetch enable after an accepted fetch matches whether a decode request was raised. They also check that a pending decode never coexists with an active stream, and that a disabled predictor always means loop mode with fetch blocked. Exiting loop mode after a mispredict is checked on every cycle as well. Only the bench scenarios can show the content of the stream: eviction between aliasing addresses, refills after a flush, the exact 28-entry loop boundary against a 30-entry overflow, and the iteration count restarting after a mispredict.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEC,
    ST_STREAM,
    ST_LOOP
  } fe_state_e;
endpackage

// File: rtl/uopc_line_store.sv
module uopc_line_store #(
  parameter int ADDR_W   = 16,
  parameter int LINES    = 256,
  parameter int MAX_UOPS = 6,
  parameter int UOP_W    = 16,
  parameter int CNT_W    = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  output logic                      hit_o,
  output logic [CNT_W-1:0]          rd_cnt_o,
  output logic [MAX_UOPS*UOP_W-1:0] rd_uops_o,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [CNT_W-1:0]          wr_cnt_i,
  input  logic [MAX_UOPS*UOP_W-1:0] wr_uops_i
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int DATA_W = MAX_UOPS * UOP_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [CNT_W-1:0]  cnt_q  [LINES];
  logic [DATA_W-1:0] uops_q [LINES];

  logic [IDX_W-1:0] r_idx, w_idx;
  logic [TAG_W-1:0] r_tag, w_tag;

  assign r_idx = rd_addr_i[IDX_W-1:0];
  assign r_tag = rd_addr_i[ADDR_W-1:IDX_W];
  assign w_idx = wr_addr_i[IDX_W-1:0];
  assign w_tag = wr_addr_i[ADDR_W-1:IDX_W];

  // flush wins over a same-cycle fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       valid_q <= '0;
    else if (flush_i)  valid_q <= '0;
    else if (wr_en_i)  valid_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[w_idx]  <= w_tag;
      cnt_q[w_idx]  <= wr_cnt_i;
      uops_q[w_idx] <= wr_uops_i;
    end
  end

  assign hit_o     = valid_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign rd_cnt_o  = cnt_q[r_idx];
  assign rd_uops_o = uops_q[r_idx];
endmodule

// File: rtl/uopc_loop_det.sv
module uopc_loop_det #(
  parameter int ADDR_W = 16,
  parameter int UOP_W  = 16,
  parameter int DEPTH  = 28,
  parameter int ITERS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [UOP_W-1:0]  push_uop_i,
  input  logic              event_i,
  input  logic [ADDR_W-1:0] event_tgt_i,
  input  logic              abort_i,
  input  logic              replay_adv_i,
  output logic              enter_o,
  output logic [UOP_W-1:0]  replay_uop_o
);
  localparam int PTR_W  = $clog2(DEPTH + 1);
  localparam int ITER_W = $clog2(ITERS + 1);

  logic [UOP_W-1:0]  body_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, len_q, rd_q;
  logic              ovf_q;
  logic [ITER_W-1:0] cnt_q;
  logic [ADDR_W-1:0] tgt_q;

  logic              room, push_ok, ovf_eff, same_tgt;
  logic [PTR_W-1:0]  len_eff;
  logic [ITER_W-1:0] cnt_nxt;

  assign room     = wr_q < PTR_W'(DEPTH);
  assign push_ok  = push_i && room;
  assign ovf_eff  = ovf_q || (push_i && !room);
  assign len_eff  = wr_q + PTR_W'(push_ok);
  assign same_tgt = (cnt_q != '0) && (tgt_q == event_tgt_i);
  assign cnt_nxt  = same_tgt ? cnt_q + ITER_W'(1) : ITER_W'(1);
  assign enter_o  = event_i && !abort_i && !ovf_eff && (len_eff != '0)
                    && (cnt_nxt >= ITER_W'(ITERS));

  always_ff @(posedge clk_i) begin
    if (push_ok) body_q[wr_q] <= push_uop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      len_q <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
      cnt_q <= '0;
      tgt_q <= '0;
    end else begin
      if (replay_adv_i)
        rd_q <= (rd_q == len_q - PTR_W'(1)) ? '0 : rd_q + PTR_W'(1);
      if (abort_i) begin
        cnt_q <= '0;
        wr_q  <= '0;
        ovf_q <= 1'b0;
      end else if (event_i) begin
        wr_q  <= '0;
        ovf_q <= 1'b0;
        tgt_q <= event_tgt_i;
        if (enter_o) begin
          cnt_q <= '0;
          len_q <= len_eff;
          rd_q  <= '0;
        end else if (ovf_eff) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end else begin
        if (push_ok)          wr_q  <= wr_q + PTR_W'(1);
        if (push_i && !room)  ovf_q <= 1'b1;
      end
    end
  end

  assign replay_uop_o = body_q[rd_q];
endmodule

// File: rtl/uop_cache_fe.sv
module uop_cache_fe #(
  parameter int ADDR_W     = 16,
  parameter int LINES      = 256,
  parameter int MAX_UOPS   = 6,
  parameter int UOP_W      = 16,
  parameter int LOOP_DEPTH = 28,
  parameter int LOOP_ITERS = 3,
  localparam int CNT_W     = $clog2(MAX_UOPS + 1),
  localparam int DATA_W    = MAX_UOPS * UOP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fetch_valid_i,
  output logic              fetch_ready_o,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_bwd_i,
  input  logic [ADDR_W-1:0] fetch_tgt_i,
  output logic              dec_req_valid_o,
  output logic [ADDR_W-1:0] dec_req_addr_o,
  input  logic              dec_rsp_valid_i,
  input  logic [CNT_W-1:0]  dec_rsp_cnt_i,
  input  logic [DATA_W-1:0] dec_rsp_uops_i,
  output logic              uop_valid_o,
  input  logic              uop_ready_i,
  output logic [UOP_W-1:0]  uop_o,
  input  logic              mispredict_i,
  output logic              fetch_en_o,
  output logic              decode_en_o,
  output logic              bpred_en_o
);
  import uopc_pkg::*;

  fe_state_e         state_q;
  logic [ADDR_W-1:0] addr_q, tgt_q;
  logic              bwd_q;
  logic [DATA_W-1:0] sbuf_q;
  logic [CNT_W-1:0]  scnt_q, sidx_q;
  logic              gate_fd_q, gate_bp_q;

  logic              hit;
  logic [CNT_W-1:0]  hit_cnt;
  logic [DATA_W-1:0] hit_uops;
  logic              fill, hs, last, enter;
  logic [UOP_W-1:0]  stream_uop, replay_uop;

  uopc_line_store #(
    .ADDR_W(ADDR_W), .LINES(LINES), .MAX_UOPS(MAX_UOPS),
    .UOP_W(UOP_W), .CNT_W(CNT_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .rd_addr_i (fetch_addr_i),
    .hit_o     (hit),
    .rd_cnt_o  (hit_cnt),
    .rd_uops_o (hit_uops),
    .wr_en_i   (fill),
    .wr_addr_i (addr_q),
    .wr_cnt_i  (dec_rsp_cnt_i),
    .wr_uops_i (dec_rsp_uops_i)
  );

  uopc_loop_det #(
    .ADDR_W(ADDR_W), .UOP_W(UOP_W), .DEPTH(LOOP_DEPTH), .ITERS(LOOP_ITERS)
  ) u_loop (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (state_q == ST_STREAM && hs),
    .push_uop_i   (stream_uop),
    .event_i      (last && bwd_q),
    .event_tgt_i  (tgt_q),
    .abort_i      (mispredict_i),
    .replay_adv_i (state_q == ST_LOOP && hs),
    .enter_o      (enter),
    .replay_uop_o (replay_uop)
  );

  assign stream_uop = sbuf_q[int'(sidx_q)*UOP_W +: UOP_W];

  assign fetch_ready_o   = (state_q == ST_IDLE);
  assign dec_req_valid_o = (state_q == ST_DEC);
  assign dec_req_addr_o  = addr_q;
  assign fill            = (state_q == ST_DEC) && dec_rsp_valid_i;
  assign uop_valid_o     = (state_q == ST_STREAM) || (state_q == ST_LOOP);
  assign uop_o           = (state_q == ST_LOOP) ? replay_uop : stream_uop;
  assign hs              = uop_valid_o && uop_ready_i;
  assign last            = (state_q == ST_STREAM) && hs && (sidx_q == scnt_q - CNT_W'(1));

  assign fetch_en_o  = gate_fd_q;
  assign decode_en_o = gate_fd_q;
  assign bpred_en_o  = gate_bp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      tgt_q     <= '0;
      bwd_q     <= 1'b0;
      sbuf_q    <= '0;
      scnt_q    <= '0;
      sidx_q    <= '0;
      gate_fd_q <= 1'b1;
      gate_bp_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fetch_valid_i) begin
          addr_q <= fetch_addr_i;
          tgt_q  <= fetch_tgt_i;
          bwd_q  <= fetch_bwd_i;
          sidx_q <= '0;
          if (hit) begin
            sbuf_q    <= hit_uops;
            scnt_q    <= hit_cnt;
            gate_fd_q <= 1'b0;
            state_q   <= (hit_cnt == '0) ? ST_IDLE : ST_STREAM;
          end else begin
            gate_fd_q <= 1'b1;
            gate_bp_q <= 1'b1;
            state_q   <= ST_DEC;
          end
        end
        ST_DEC: if (dec_rsp_valid_i) begin
          sbuf_q  <= dec_rsp_uops_i;
          scnt_q  <= dec_rsp_cnt_i;
          state_q <= (dec_rsp_cnt_i == '0) ? ST_IDLE : ST_STREAM;
        end
        ST_STREAM: if (hs) begin
          if (last) begin
            if (enter) begin
              state_q   <= ST_LOOP;
              gate_fd_q <= 1'b0;
              gate_bp_q <= 1'b0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            sidx_q <= sidx_q + CNT_W'(1);
          end
        end
        ST_LOOP: if (mispredict_i) begin
          state_q   <= ST_IDLE;
          gate_fd_q <= 1'b1;
          gate_bp_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uopc_sva.sv
module uopc_sva #(
  parameter int UOP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_valid_i,
  input logic             fetch_ready_o,
  input logic             dec_req_valid_o,
  input logic             uop_valid_o,
  input logic             uop_ready_i,
  input logic [UOP_W-1:0] uop_o,
  input logic             mispredict_i,
  input logic             fetch_en_o,
  input logic             decode_en_o,
  input logic             bpred_en_o
);
  a_r6_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_o && !uop_ready_i && !mispredict_i |=> uop_valid_o && $stable(uop_o));

  a_r4_gate_tracks_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && fetch_ready_o |=> (dec_req_valid_o == fetch_en_o));

  a_r5_decode_on_while_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_req_valid_o |-> fetch_en_o && decode_en_o && !uop_valid_o);

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_o |-> !uop_valid_o && !dec_req_valid_o);

  a_r7_loop_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bpred_en_o |-> !fetch_en_o && !decode_en_o && !fetch_ready_o && uop_valid_o);

  a_r9_mispredict_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_i && !bpred_en_o |=> bpred_en_o && fetch_en_o && decode_en_o && fetch_ready_o);
endmodule

bind uop_cache_fe uopc_sva #(.UOP_W(UOP_W)) u_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_valid_i   (fetch_valid_i),
  .fetch_ready_o   (fetch_ready_o),
  .dec_req_valid_o (dec_req_valid_o),
  .uop_valid_o     (uop_valid_o),
  .uop_ready_i     (uop_ready_i),
  .uop_o           (uop_o),
  .mispredict_i    (mispredict_i),
  .fetch_en_o      (fetch_en_o),
  .decode_en_o     (decode_en_o),
  .bpred_en_o      (bpred_en_o)
);

// File: tb/uop_cache_fe_tb_top.sv
module uop_cache_fe_tb_top;
  localparam int AW = 16;
  localparam int UW = 16;
  localparam int MU = 6;
  localparam int CW = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic           flush_i = 1'b0, fetch_valid_i = 1'b0, fetch_bwd_i = 1'b0;
  logic [AW-1:0]  fetch_addr_i = '0, fetch_tgt_i = '0;
  logic           dec_rsp_valid_i = 1'b0;
  logic [CW-1:0]  dec_rsp_cnt_i = '0;
  logic [MU*UW-1:0] dec_rsp_uops_i = '0;
  logic           uop_ready_i = 1'b0, mispredict_i = 1'b0;
  logic           fetch_ready_o, dec_req_valid_o, uop_valid_o;
  logic [AW-1:0]  dec_req_addr_o;
  logic [UW-1:0]  uop_o;
  logic           fetch_en_o, decode_en_o, bpred_en_o;

  uop_cache_fe dut_i (
    .clk_i, .rst_ni, .flush_i, .fetch_valid_i, .fetch_ready_o, .fetch_addr_i,
    .fetch_bwd_i, .fetch_tgt_i, .dec_req_valid_o, .dec_req_addr_o,
    .dec_rsp_valid_i, .dec_rsp_cnt_i, .dec_rsp_uops_i, .uop_valid_o,
    .uop_ready_i, .uop_o, .mispredict_i, .fetch_en_o, .decode_en_o, .bpred_en_o
  );

  int checks = 0, errors = 0, dec_reqs = 0;
  logic [AW-1:0] last_req_addr = '0;
  logic [UW-1:0] exp_q[$];
  bit            mvalid[256];
  logic [7:0]    mtag[256];
  logic [7:0]    lfsr = 8'h5a;
  bit            held_v = 0;
  logic [UW-1:0] held_d;

  function automatic int cnt_of(input logic [AW-1:0] a);
    return (int'(a) % 6) + 1;
  endfunction
  function automatic logic [UW-1:0] uop_of(input logic [AW-1:0] a, input int i);
    return {a[12:0], 3'(i)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // decoder model
  initial begin
    forever begin
      @(negedge clk_i);
      if (dec_req_valid_o) begin
        logic [AW-1:0] a;
        dec_reqs++;
        a = dec_req_addr_o;
        last_req_addr = a;
        repeat (2) @(negedge clk_i);
        dec_rsp_uops_i = '0;
        for (int i = 0; i < cnt_of(a); i++) dec_rsp_uops_i[i*UW +: UW] = uop_of(a, i);
        dec_rsp_cnt_i   = CW'(cnt_of(a));
        dec_rsp_valid_i = 1'b1;
        @(negedge clk_i);
        dec_rsp_valid_i = 1'b0;
      end
    end
  end

  // consumer backpressure
  initial begin
    forever begin
      @(negedge clk_i);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      uop_ready_i = (exp_q.size() > 0) && (lfsr[0] | lfsr[1]);
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (held_v) begin
        chk("R6", "stall valid", int'(uop_valid_o), 1);
        chk("R6", "stall data", int'(uop_o), int'(held_d));
      end
      held_v = uop_valid_o && !uop_ready_i && !mispredict_i && rst_ni;
      held_d = uop_o;
      if (uop_valid_o && uop_ready_i) begin
        if (exp_q.size() == 0) chk("R5", "unexpected uop", int'(uop_o), -1);
        else chk("R4/R5/R7", "uop order", int'(uop_o), int'(exp_q.pop_front()));
      end
    end
  end

  task automatic do_fetch(input logic [AW-1:0] a, input bit bwd, input logic [AW-1:0] tgt);
    bit exp_hit;
    int r0;
    exp_hit = mvalid[a[7:0]] && (mtag[a[7:0]] == a[15:8]);
    while (!fetch_ready_o) @(negedge clk_i);
    r0 = dec_reqs;
    fetch_valid_i = 1'b1; fetch_addr_i = a; fetch_bwd_i = bwd; fetch_tgt_i = tgt;
    @(negedge clk_i);
    fetch_valid_i = 1'b0;
    if (exp_hit) begin
      chk("R4", "fetch_en after hit", int'(fetch_en_o), 0);
      chk("R4", "bpred_en after hit", int'(bpred_en_o), 1);
    end else begin
      chk("R5", "decode_en after miss", int'(decode_en_o), 1);
    end
    for (int i = 0; i < cnt_of(a); i++) exp_q.push_back(uop_of(a, i));
    mvalid[a[7:0]] = 1; mtag[a[7:0]] = a[15:8];
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
    chk(exp_hit ? "R3" : "R2", "decoder requests", dec_reqs - r0, exp_hit ? 0 : 1);
    if (!exp_hit) chk("R3", "request address", int'(last_req_addr), int'(a));
  endtask

  task automatic pulse_mispredict();
    mispredict_i = 1'b1;
    @(negedge clk_i);
    mispredict_i = 1'b0;
  endtask

  task automatic run_iters(input logic [AW-1:0] addrs[$], input int n);
    for (int it = 0; it < n; it++)
      for (int g = 0; g < addrs.size(); g++)
        do_fetch(addrs[g], g == addrs.size() - 1, addrs[0]);
  endtask

  initial begin
    logic [AW-1:0] body[$];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "fetch_ready", int'(fetch_ready_o), 1);
    chk("R11", "uop_valid", int'(uop_valid_o), 0);
    chk("R11", "dec_req", int'(dec_req_valid_o), 0);
    chk("R11", "fetch_en", int'(fetch_en_o), 1);
    chk("R11", "bpred_en", int'(bpred_en_o), 1);

    // R2 R3 R4 R5: fill then hit
    do_fetch(16'h0010, 0, 0);
    do_fetch(16'h0023, 0, 0);
    do_fetch(16'h0010, 0, 0);
    do_fetch(16'h0023, 0, 0);
    // R1: aliasing index evicts
    do_fetch(16'h0110, 0, 0);
    do_fetch(16'h0010, 0, 0);
    do_fetch(16'h0010, 0, 0);
    // R10: flush
    flush_i = 1'b1; @(negedge clk_i); flush_i = 1'b0;
    for (int i = 0; i < 256; i++) mvalid[i] = 0;
    do_fetch(16'h0023, 0, 0);
    do_fetch(16'h0010, 0, 0);
    // mixed traffic
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 12; i++) do_fetch(16'h0040 + AW'(i * 3), 0, 0);

    // R7: two-group loop, body 3+4 = 7
    pulse_mispredict();
    body = '{16'h0200, 16'h0201};
    run_iters(body, 3);
    chk("R7", "fetch_ready in loop", int'(fetch_ready_o), 0);
    chk("R7", "fetch_en in loop", int'(fetch_en_o), 0);
    chk("R7", "decode_en in loop", int'(decode_en_o), 0);
    chk("R7", "bpred_en in loop", int'(bpred_en_o), 0);
    for (int r = 0; r < 2; r++)
      foreach (body[g]) for (int i = 0; i < cnt_of(body[g]); i++) exp_q.push_back(uop_of(body[g], i));
    for (int i = 0; i < 2; i++) exp_q.push_back(uop_of(body[0], i));
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
    chk("R7", "still replaying", int'(uop_valid_o), 1);
    pulse_mispredict();
    chk("R9", "fetch_ready after exit", int'(fetch_ready_o), 1);
    chk("R9", "fetch_en after exit", int'(fetch_en_o), 1);
    chk("R9", "bpred_en after exit", int'(bpred_en_o), 1);

    // R7 boundary: 6+6+6+6+4 = 28 enters
    pulse_mispredict();
    body = '{16'h0305, 16'h030B, 16'h0311, 16'h0317, 16'h031B};
    run_iters(body, 3);
    chk("R7", "28-entry body enters loop", int'(bpred_en_o), 0);
    pulse_mispredict();
    chk("R9", "exit after 28 loop", int'(fetch_ready_o), 1);

    // R8: 30-entry body never enters
    body = '{16'h0305, 16'h030B, 16'h0311, 16'h0317, 16'h031D};
    run_iters(body, 4);
    chk("R8", "overflow stays out of loop", int'(fetch_ready_o), 1);
    chk("R8", "overflow bpred_en", int'(bpred_en_o), 1);

    // R9: mispredict restarts count
    pulse_mispredict();
    body = '{16'h0200, 16'h0201};
    run_iters(body, 2);
    pulse_mispredict();
    run_iters(body, 1);
    chk("R9", "count restarted", int'(fetch_ready_o), 1);
    chk("R9", "count restarted bpred", int'(bpred_en_o), 1);

    repeat (4) @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule